// File: doc/BRIEF.md
# Multi-Mode Logarithmic Barrel Shifter

This block is a purely combinational barrel shifter. It takes a data word, a shift amount and an operation code, and it returns the shifted or rotated word in the same cycle. Five operations are available: rotate right, logical right shift, arithmetic right shift, rotate left and logical left shift.

All five operations share one right-shifting core. The core has one stage for each bit of the amount. Each stage either moves the word toward the least significant end by a power of two or passes it through unchanged. A fill control sets what enters the vacated upper positions of each stage: the bits that fall off the bottom (rotates), zeros (logical shifts) or the original sign bit (arithmetic shift).

Left operations do not use a second shifter. The block mirrors the bit order of the word before the core and mirrors it back after the core. Any operation code outside the five defined ones returns the input word unchanged.

Top module: `multimode_barrel_shifter`

## Requirements
- R1: With op = 3'b000 (rotate right), dout equals din rotated toward bit 0 by amt positions. Bits leaving bit 0 re-enter at bit W-1.
- R2: With op = 3'b001 (logical right shift), dout equals din shifted toward bit 0 by amt positions, with zeros in the top amt bits.
- R3: With op = 3'b010 (arithmetic right shift), dout equals din shifted toward bit 0 by amt positions. The top amt bits are copies of din[W-1].
- R4: With op = 3'b011 (rotate left), dout equals din rotated toward bit W-1 by amt positions. Bits leaving bit W-1 re-enter at bit 0.
- R5: With op = 3'b100 (logical left shift), dout equals din shifted toward bit W-1 by amt positions, with zeros in the low amt bits.
- R6: When amt = 0, dout equals din for every operation code.
- R7: Codes 3'b101, 3'b110 and 3'b111 return din unchanged for every amount.
- R8: When din[W-1] = 0, the arithmetic right shift gives the same result as the logical right shift for every amount.
- R9: Both rotate operations keep the number of set bits: the count of ones in dout equals the count of ones in din.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | W (32) | Data word to shift or rotate |
| amt  | input  | clog2(W) (5) | Shift or rotate distance |
| op   | input  | 3 | Operation select (encoding in R1 to R5, R7) |
| dout | output | W (32) | Result word |

## Verification
The block has no registers, so every result is due in the same cycle its inputs are applied, with zero cycles of latency. The bench changes din, amt and op on the falling clock edge. It reads dout one nanosecond later, well before the next rising edge, so each sample sees only the settled value of the current stimulus.

The sweep covers all eight operation codes and all 32 amounts. It uses edge patterns (all ones, only the most significant bit set, only bit 0 set, alternating bits, a single walking bit) and random words. Each sample is compared with a reference that the bench computes from double-width concatenations.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [2:0] {
    OP_ROR = 3'b000,
    OP_LSR = 3'b001,
    OP_ASR = 3'b010,
    OP_ROL = 3'b011,
    OP_LSL = 3'b100
  } op_e;

  typedef enum logic [1:0] {
    FILL_WRAP = 2'd0,
    FILL_ZERO = 2'd1,
    FILL_SIGN = 2'd2
  } fill_e;

  typedef struct packed {
    logic  mirror;
    fill_e fill;
    logic  bypass;
  } ctrl_t;

  // Map an operation code to the controls of the shared right-shift path.
  function automatic ctrl_t decode_op(input logic [2:0] code);
    ctrl_t c;
    c.mirror = 1'b0;
    c.fill   = FILL_ZERO;
    c.bypass = 1'b0;
    case (code)
      OP_ROR: c.fill = FILL_WRAP;
      OP_LSR: c.fill = FILL_ZERO;
      OP_ASR: c.fill = FILL_SIGN;
      OP_ROL: begin c.fill = FILL_WRAP; c.mirror = 1'b1; end
      OP_LSL: begin c.fill = FILL_ZERO; c.mirror = 1'b1; end
      default: c.bypass = 1'b1;
    endcase
    return c;
  endfunction

  function automatic logic is_rotate(input logic [2:0] code);
    return (code == OP_ROR) || (code == OP_ROL);
  endfunction

endpackage

// File: rtl/bshift_mirror.sv
module bshift_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  logic [W-1:0] flipped;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped[i] = din[W-1-i];
  end

  assign dout = en ? flipped : din;

  always_comb begin
    if (en) begin
      AST_MIRROR_ENDS: assert (dout[0] == din[W-1] && dout[W-1] == din[0]); // R4
    end else begin
      AST_MIRROR_PASS: assert (dout == din); // R1
    end
  end
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
  import bshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int SHIFT = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  fill_e        fill,
  input  logic         sign,
  output logic [W-1:0] dout
);
  logic [SHIFT-1:0] fill_bits;

  always_comb begin
    case (fill)
      FILL_WRAP: fill_bits = din[SHIFT-1:0];
      FILL_SIGN: fill_bits = {SHIFT{sign}};
      default:   fill_bits = '0;
    endcase
  end

  assign dout = en ? {fill_bits, din[W-1:SHIFT]} : din;

  always_comb begin
    if (en && fill == FILL_ZERO) begin
      AST_STAGE_ZERO_FILL: assert (dout[W-1 -: SHIFT] == '0); // R2
    end
    if (en && fill == FILL_SIGN) begin
      AST_STAGE_SIGN_FILL: assert (dout[W-1 -: SHIFT] == {SHIFT{sign}}); // R3
    end
    if (en && fill == FILL_WRAP) begin
      AST_STAGE_WRAP_COUNT: assert ($countones(dout) == $countones(din)); // R9
    end
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  fill_e         fill,
  input  logic          sign,
  output logic [W-1:0]  dout
);
  logic [W-1:0] tap [AW+1];

  assign tap[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    bshift_stage #(.W(W), .SHIFT(1 << k)) u_stage (
      .din  (tap[k]),
      .en   (amt[k]),
      .fill (fill),
      .sign (sign),
      .dout (tap[k+1])
    );
  end

  assign dout = tap[AW];

  always_comb begin
    if (amt == '0) begin
      AST_CORE_ZERO_AMT: assert (dout == din); // R6
    end
  end
endmodule

// File: rtl/multimode_barrel_shifter.sv
module multimode_barrel_shifter
  import bshift_pkg::*;
#(
  parameter  int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [2:0]    op,
  output logic [W-1:0]  dout
);
  ctrl_t        ctrl;
  logic [W-1:0] pre_word;
  logic [W-1:0] core_word;
  logic [W-1:0] post_word;
  logic         rotate_op;

  assign ctrl      = decode_op(op);
  assign rotate_op = is_rotate(op);

  bshift_mirror #(.W(W)) u_pre (
    .din  (din),
    .en   (ctrl.mirror),
    .dout (pre_word)
  );

  bshift_core #(.W(W), .AW(AW)) u_core (
    .din  (pre_word),
    .amt  (amt),
    .fill (ctrl.fill),
    .sign (din[W-1]),
    .dout (core_word)
  );

  bshift_mirror #(.W(W)) u_post (
    .din  (core_word),
    .en   (ctrl.mirror),
    .dout (post_word)
  );

  assign dout = ctrl.bypass ? din : post_word;

  always_comb begin
    if (amt == '0) begin
      AST_ZERO_AMT_IDENT: assert (dout == din); // R6
    end
    if (op > 3'b100) begin
      AST_UNDEF_OP_IDENT: assert (dout == din); // R7
    end
    if (rotate_op) begin
      AST_ROT_POPCOUNT: assert ($countones(dout) == $countones(din)); // R9
    end
    if (op == OP_LSR && amt != '0) begin
      AST_LSR_TOP_ZERO: assert (dout[W-1] == 1'b0); // R2
    end
    if (op == OP_ASR) begin
      AST_ASR_TOP_SIGN: assert (dout[W-1] == din[W-1]); // R3
    end
    if (op == OP_LSL && amt != '0) begin
      AST_LSL_LOW_ZERO: assert (dout[0] == 1'b0); // R5
    end
    if (op == OP_ROR && amt == AW'(1)) begin
      AST_ROR_ONE_WRAP: assert (dout[W-1] == din[0]); // R1
    end
    if (op == OP_ROL && amt == AW'(1)) begin
      AST_ROL_ONE_WRAP: assert (dout[0] == din[W-1]); // R4
    end
  end
endmodule

// File: tb/multimode_barrel_shifter_bench.sv
`timescale 1ns/1ps
module multimode_barrel_shifter_bench;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  din;
  logic [AW-1:0] amt;
  logic [2:0]    op;
  logic [W-1:0]  dout;
  int            n_checks = 0;
  int            n_errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  multimode_barrel_shifter u_multimode_barrel_shifter (
    .din(din), .amt(amt), .op(op), .dout(dout)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int n, input int code);
    logic [2*W-1:0] dbl;
    dbl = {d, d};
    case (code)
      0: return dbl[W-1:0] >> 0 == 0 ? W'(dbl >> n) : W'(dbl >> n);
      1: return d >> n;
      2: begin
        dbl = {{W{d[W-1]}}, d};
        return W'(dbl >> n);
      end
      3: begin
        dbl = {d, d} << n;
        return dbl[2*W-1:W];
      end
      4: return d << n;
      default: return d;
    endcase
  endfunction

  function automatic string tag_of(input int code, input int n);
    if (n == 0) return "R6";
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: op=%0d amt=%0d din=%h actual=%h expected=%h", tag, op, amt, din, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input int n, input int code);
    @(negedge clk);
    din = d;
    amt = AW'(n);
    op  = 3'(code);
    #1;
    check(tag_of(code, n), dout, model(d, n, code));
    if (code == 0 || code == 3) begin
      n_checks++;
      if ($countones(dout) != $countones(d)) begin
        n_errors++;
        $display("FAIL R9: popcount actual=%0d expected=%0d", $countones(dout), $countones(d));
      end
    end
  endtask

  task automatic sweep(input logic [W-1:0] d);
    for (int code = 0; code < 8; code++)
      for (int n = 0; n < W; n++)
        apply(d, n, code);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    din = '0; amt = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R6", dout, '0);   // quiet state with all-zero inputs

    sweep('1);
    sweep(32'h8000_0000);
    sweep(32'h0000_0001);
    sweep(32'hA5A5_5A5A);
    sweep(32'h7FFF_FFFF);
    for (int b = 0; b < W; b += 7) sweep(W'(1) << b);
    for (int r = 0; r < 6; r++) sweep($urandom());

    // R8: with the top bit clear, the arithmetic and logical right shifts agree
    for (int r = 0; r < 4; r++) begin
      logic [W-1:0] d;
      logic [W-1:0] lsr_res;
      d = $urandom() & 32'h7FFF_FFFF;
      for (int n = 0; n < W; n++) begin
        apply(d, n, 1);
        lsr_res = dout;
        apply(d, n, 2);
        check("R8", dout, lsr_res);
      end
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule